// File: doc/BRIEF.md
# Remote DMA Channel Engine

This block transfers data between a host-facing data port and a local buffer RAM on behalf of a control block. The host first loads a 16-bit buffer address and a 16-bit transfer length, one byte at a time. The control block then issues a 3-bit command that starts a read from the buffer or a write into it. Each time the host touches the data port, the engine makes one memory access of one byte or one 16-bit word, as set by the width select. That access moves the address forward and lowers the remaining length.

The buffer RAM is reached through a single request/grant pair, which it shares with the receive logic. The current address is visible at all times, so the host can track progress while a transfer runs. When the remaining length reaches zero, the engine posts a one-cycle completion event. That event feeds the remote-DMA-complete status bit.

Any command with its top bit set aborts the transfer within a cycle. An abort leaves the address at its advanced value and does not clear the remaining length.

Top module: `rdma_engine`

## Requirements
- R1: After reset, cur_addr_o is 0, busy_o, done_o, port_ack_o and mem_req_o are 0, and port_rdata_o is 0.
- R2: While idle, a reg_we_i write sets a byte of a pointer, selected by reg_sel_i: 0 is the address low byte, 1 the address high byte, 2 the count low byte, 3 the count high byte. While busy_o is 1, these writes are ignored.
- R3: A cmd_valid_i pulse with cmd_i = 001 starts a buffer read and 010 starts a buffer write, but only when the engine is idle. A command of 000 or 011 has no effect. Any command of 1xx is an abort.
- R4: Each granted access (mem_req_o and mem_gnt_i both 1) advances cur_addr_o by 1 when word_mode_i=0 or by 2 when word_mode_i=1. It lowers the remaining count by the same amount, stopping at 0.
- R5: In byte mode, mem_be_o is 01 and read data is mem_rdata_i[7:0] zero-extended. In word mode, mem_be_o is 11 and all 16 bits pass through. mem_we_o is 1 for a write transfer.
- R6: A port access that matches the active direction holds mem_req_o high until granted. port_ack_o is a one-cycle pulse in the cycle after the grant, and read data on port_rdata_o is valid with it.
- R7: While busy, when the remaining count is 0, busy_o drops and done_o pulses for one cycle. A start with a count of 0 completes this way with no memory access.
- R8: A port access made while idle, or in the direction opposite to the active transfer, is acked the next cycle with port_rdata_o = 0. It makes no memory access and leaves cur_addr_o unchanged.
- R9: In an abort cycle mem_req_o is 0. busy_o is 0 from the next cycle, done_o does not pulse, and cur_addr_o keeps its advanced value. The remaining count is kept, so a restart continues it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| word_mode_i | input | 1 | 1 selects word accesses, 0 selects byte accesses |
| reg_we_i | input | 1 | Pointer byte write strobe |
| reg_sel_i | input | 2 | Pointer byte select |
| reg_wdata_i | input | 8 | Pointer byte value |
| cur_addr_o | output | 16 | Current buffer address |
| busy_o | output | 1 | Transfer active |
| done_o | output | 1 | Completion event pulse |
| port_rd_i | input | 1 | Host data port read request |
| port_wr_i | input | 1 | Host data port write request |
| port_wdata_i | input | 16 | Host write data |
| port_rdata_o | output | 16 | Host read data |
| port_ack_o | output | 1 | Data port access acknowledge |
| mem_req_o | output | 1 | Buffer RAM request |
| mem_gnt_i | input | 1 | Buffer RAM grant |
| mem_we_o | output | 1 | Buffer RAM write enable |
| mem_be_o | output | 2 | Buffer RAM byte enables |
| mem_addr_o | output | 16 | Buffer RAM byte address |
| mem_wdata_o | output | 16 | Buffer RAM write data |
| mem_rdata_i | input | 16 | Buffer RAM read data |

## Verification
A wrong address step shows on cur_addr_o one cycle after the grant. It also shows in the buffer contents at the next access. A wrong remaining count shows as a done_o pulse that comes one access too early or too late, or never comes. A stale busy or direction state shows within one cycle, as an access that is acked with zero data instead of reaching memory. Abort faults show in the cycle after the abort: busy_o is still high, done_o fires, or a stray write lands in memory.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  localparam logic [2:0] CMD_NONE = 3'b000;
  localparam logic [2:0] CMD_RD   = 3'b001;
  localparam logic [2:0] CMD_WR   = 3'b010;
  localparam logic [2:0] CMD_SEND = 3'b011;

  typedef enum logic [1:0] {
    SEL_ADDR_LO = 2'd0,
    SEL_ADDR_HI = 2'd1,
    SEL_CNT_LO  = 2'd2,
    SEL_CNT_HI  = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/rdma_ptr_regs.sv
module rdma_ptr_regs import rdma_pkg::*; #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [1:0]        sel_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              adv_i,
  input  logic              wide_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              cnt_zero_o
);
  localparam int AHI_W = ADDR_W - BYTE_W;
  localparam int CHI_W = CNT_W - BYTE_W;

  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        step;
  logic [CNT_W-1:0]  step_c;

  assign step   = wide_i ? 2'd2 : 2'd1;
  assign step_c = {{(CNT_W-2){1'b0}}, step};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (adv_i) begin
      addr_q <= addr_q + {{(ADDR_W-2){1'b0}}, step};
      cnt_q  <= (cnt_q <= step_c) ? '0 : cnt_q - step_c;
    end else if (load_i) begin
      unique case (ptr_sel_e'(sel_i))
        SEL_ADDR_LO: addr_q[BYTE_W-1:0]      <= wdata_i;
        SEL_ADDR_HI: addr_q[ADDR_W-1:BYTE_W] <= AHI_W'(wdata_i);
        SEL_CNT_LO:  cnt_q[BYTE_W-1:0]       <= wdata_i;
        SEL_CNT_HI:  cnt_q[CNT_W-1:BYTE_W]   <= CHI_W'(wdata_i);
        default: ;
      endcase
    end
  end

  assign addr_o     = addr_q;
  assign cnt_zero_o = (cnt_q == '0);
endmodule

// File: rtl/rdma_ctrl.sv
module rdma_ctrl import rdma_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [2:0] cmd_i,
  input  logic       cnt_zero_i,
  input  logic       port_rd_i,
  input  logic       port_wr_i,
  input  logic       mem_gnt_i,
  output logic       busy_o,
  output logic       dir_wr_o,
  output logic       mem_req_o,
  output logic       grant_o,
  output logic       ignore_o,
  output logic       ack_o,
  output logic       done_o
);
  logic busy_q, dir_q, ack_q, done_q;
  logic abort, start, match, access;

  assign abort  = cmd_valid_i && cmd_i[2];
  assign start  = cmd_valid_i && !busy_q && (cmd_i == CMD_RD || cmd_i == CMD_WR);
  assign match  = dir_q ? port_wr_i : port_rd_i;
  assign access = port_rd_i || port_wr_i;

  // matching access waits for grant; anything else is acked empty
  assign mem_req_o = busy_q && match && !ack_q && !cnt_zero_i && !abort;
  assign grant_o   = mem_req_o && mem_gnt_i;
  assign ignore_o  = access && !ack_q && !(busy_q && match);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      ack_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (abort)       busy_q <= 1'b0;
      else if (busy_q) busy_q <= !cnt_zero_i;
      else             busy_q <= start;
      if (start) dir_q <= (cmd_i == CMD_WR);
      ack_q  <= grant_o || ignore_o;
      done_q <= busy_q && cnt_zero_i && !abort;
    end
  end

  assign busy_o   = busy_q;
  assign dir_wr_o = dir_q;
  assign ack_o    = ack_q;
  assign done_o   = done_q;
endmodule

// File: rtl/rdma_engine.sv
module rdma_engine import rdma_pkg::*; #(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cmd_valid_i,
  input  logic [2:0]          cmd_i,
  input  logic                word_mode_i,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_sel_i,
  input  logic [BYTE_W-1:0]   reg_wdata_i,
  output logic [ADDR_W-1:0]   cur_addr_o,
  output logic                busy_o,
  output logic                done_o,
  input  logic                port_rd_i,
  input  logic                port_wr_i,
  input  logic [2*BYTE_W-1:0] port_wdata_i,
  output logic [2*BYTE_W-1:0] port_rdata_o,
  output logic                port_ack_o,
  output logic                mem_req_o,
  input  logic                mem_gnt_i,
  output logic                mem_we_o,
  output logic [1:0]          mem_be_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*BYTE_W-1:0] mem_wdata_o,
  input  logic [2*BYTE_W-1:0] mem_rdata_i
);
  localparam int WORD_W = 2 * BYTE_W;

  logic cnt_zero, busy, dir_wr, grant, ignore;
  logic [WORD_W-1:0] rdata_q, rd_lane;

  rdma_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .cnt_zero_i  (cnt_zero),
    .port_rd_i   (port_rd_i),
    .port_wr_i   (port_wr_i),
    .mem_gnt_i   (mem_gnt_i),
    .busy_o      (busy),
    .dir_wr_o    (dir_wr),
    .mem_req_o   (mem_req_o),
    .grant_o     (grant),
    .ignore_o    (ignore),
    .ack_o       (port_ack_o),
    .done_o      (done_o)
  );

  rdma_ptr_regs #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (reg_we_i && !busy),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .adv_i      (grant),
    .wide_i     (word_mode_i),
    .addr_o     (cur_addr_o),
    .cnt_zero_o (cnt_zero)
  );

  assign rd_lane = word_mode_i ? mem_rdata_i : {{BYTE_W{1'b0}}, mem_rdata_i[BYTE_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (grant)  rdata_q <= dir_wr ? '0 : rd_lane;
    else if (ignore) rdata_q <= '0;
  end

  assign busy_o       = busy;
  assign port_rdata_o = rdata_q;
  assign mem_we_o     = dir_wr;
  assign mem_be_o     = word_mode_i ? 2'b11 : 2'b01;
  assign mem_addr_o   = cur_addr_o;
  assign mem_wdata_o  = port_wdata_i;
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_i,
  input logic              word_mode_i,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              port_ack_o,
  input logic              mem_req_o,
  input logic              mem_gnt_i
);
  a_r6_req_needs_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r6_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_ack_o |=> !port_ack_o);

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_done_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (!busy_o && $past(busy_o)));

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_gnt_i) |=>
      (cur_addr_o == $past(cur_addr_o) + ADDR_W'($past(word_mode_i) ? 2 : 1)));

  a_r9_abort_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[2]) |-> !mem_req_o);

  a_r9_abort_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[2]) |=> (!busy_o && !done_o));
endmodule

bind rdma_engine rdma_engine_chk #(.ADDR_W(ADDR_W)) i_rdma_engine_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .word_mode_i (word_mode_i),
  .cur_addr_o  (cur_addr_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .port_ack_o  (port_ack_o),
  .mem_req_o   (mem_req_o),
  .mem_gnt_i   (mem_gnt_i)
);

// File: tb/test_rdma_engine.sv
`timescale 1ns/1ps
module test_rdma_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'b000;
  logic        word_mode = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [7:0]  reg_wdata = 8'h00;
  logic [15:0] cur_addr;
  logic        busy, done;
  logic        port_rd = 1'b0, port_wr = 1'b0;
  logic [15:0] port_wdata = 16'h0000;
  logic [15:0] port_rdata;
  logic        port_ack;
  logic        mem_req, mem_we;
  logic        gnt_hold = 1'b0;
  logic [1:0]  mem_be;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [7:0]  mem [256];

  int n_cmp = 0, n_bad = 0;
  int done_seen = 0, gnt_seen = 0;

  always #10 clk = ~clk;

  rdma_engine i_rdma_engine (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .word_mode_i(word_mode), .reg_we_i(reg_we), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .cur_addr_o(cur_addr), .busy_o(busy), .done_o(done),
    .port_rd_i(port_rd), .port_wr_i(port_wr), .port_wdata_i(port_wdata),
    .port_rdata_o(port_rdata), .port_ack_o(port_ack), .mem_req_o(mem_req),
    .mem_gnt_i(!gnt_hold), .mem_we_o(mem_we), .mem_be_o(mem_be),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  assign mem_rdata = {mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};

  always @(posedge clk) begin
    if (mem_req && !gnt_hold && mem_we) begin
      if (mem_be[0]) mem[mem_addr[7:0]] <= mem_wdata[7:0];
      if (mem_be[1]) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
    end
  end

  always @(negedge clk) begin
    if (done) done_seen++;
    if (mem_req && !gnt_hold) gnt_seen++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [7:0] v);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic load(input logic [15:0] a, input logic [15:0] c);
    reg_write(2'd0, a[7:0]); reg_write(2'd1, a[15:8]);
    reg_write(2'd2, c[7:0]); reg_write(2'd3, c[15:8]);
  endtask

  task automatic issue(input logic [2:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0; cmd = 3'b000;
  endtask

  task automatic host(input bit wr, input logic [15:0] wd, output logic [15:0] rd);
    @(negedge clk); port_wr = wr; port_rd = !wr; port_wdata = wd;
    do @(negedge clk); while (!port_ack);
    rd = port_rdata; port_rd = 1'b0; port_wr = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 addr", cur_addr, 0); check("R1 busy", busy, 0);
    check("R1 done", done, 0);     check("R1 ack", port_ack, 0);
    check("R1 req", mem_req, 0);   check("R1 rdata", port_rdata, 0);
  endtask

  task automatic t_byte_write;
    logic [15:0] rd;
    int d0;
    word_mode = 1'b0;
    load(16'h0110, 16'd3);
    check("R2 addr load", cur_addr, 16'h0110);
    issue(3'b010);
    check("R3 write start", busy, 1);
    d0 = done_seen;
    host(1'b1, 16'hFF5A, rd);
    check("R4 byte step", cur_addr, 16'h0111);
    host(1'b1, 16'h0066, rd);
    host(1'b1, 16'h0077, rd);
    repeat (3) @(negedge clk);
    check("R5 byte lane 0", mem[8'h10], 8'h5A);
    check("R5 byte lane 1", mem[8'h11], 8'h66);
    check("R5 byte lane 2", mem[8'h12], 8'h77);
    check("R5 upper untouched", mem[8'h13], 8'hEE);
    check("R7 one done", done_seen - d0, 1);
    check("R7 busy fell", busy, 0);
    check("R4 final addr", cur_addr, 16'h0113);
  endtask

  task automatic t_word_read;
    logic [15:0] rd;
    int g0;
    mem[8'h20] = 8'h11; mem[8'h21] = 8'h22; mem[8'h22] = 8'h33; mem[8'h23] = 8'h44;
    word_mode = 1'b1;
    load(16'h0020, 16'd4);
    issue(3'b001);
    g0 = gnt_seen;
    host(1'b1, 16'hDEAD, rd);  // wrong direction
    check("R8 mismatch rdata", rd, 0);
    check("R8 mismatch no access", gnt_seen - g0, 0);
    check("R8 mismatch addr", cur_addr, 16'h0020);
    check("R8 mismatch mem", mem[8'h20], 8'h11);
    host(1'b0, 16'h0, rd);
    check("R5 word read 0", rd, 16'h2211);
    host(1'b0, 16'h0, rd);
    check("R5 word read 1", rd, 16'h4433);
    check("R4 word step", cur_addr, 16'h0024);
    repeat (3) @(negedge clk);
    check("R7 read done", busy, 0);
    word_mode = 1'b0;
    load(16'h0021, 16'd1);
    issue(3'b001);
    host(1'b0, 16'h0, rd);
    check("R5 byte read zero-ext", rd, 16'h0022);
  endtask

  task automatic t_odd_word;
    logic [15:0] rd;
    int d0;
    word_mode = 1'b1;
    load(16'h0030, 16'd3);
    issue(3'b010);
    d0 = done_seen;
    host(1'b1, 16'hA1B2, rd);
    host(1'b1, 16'hC3D4, rd);
    repeat (3) @(negedge clk);
    check("R5 word write lo", mem[8'h30], 8'hB2);
    check("R5 word write hi", mem[8'h33], 8'hC3);
    check("R4 count floors at zero", done_seen - d0, 1);
    check("R4 odd addr", cur_addr, 16'h0034);
  endtask

  task automatic t_stall;
    logic [15:0] rd;
    word_mode = 1'b0;
    load(16'h0050, 16'd1);
    issue(3'b010);
    @(negedge clk); gnt_hold = 1'b1;
    fork
      host(1'b1, 16'h00C7, rd);
      begin
        repeat (4) @(negedge clk);
        check("R6 req held", mem_req, 1);
        check("R6 no early ack", port_ack, 0);
        check("R6 no early write", mem[8'h50], 8'hEE);
        gnt_hold = 1'b0;
      end
    join
    repeat (2) @(negedge clk);
    check("R6 stalled write lands", mem[8'h50], 8'hC7);
  endtask

  task automatic t_idle_and_cmds;
    logic [15:0] rd;
    int g0, d0;
    load(16'h0060, 16'd2);
    g0 = gnt_seen;
    host(1'b0, 16'h0, rd);
    check("R8 idle rdata", rd, 0);
    host(1'b1, 16'h0099, rd);
    check("R8 idle no access", gnt_seen - g0, 0);
    check("R8 idle mem", mem[8'h60], 8'hEE);
    check("R8 idle addr", cur_addr, 16'h0060);
    issue(3'b000);
    check("R3 cmd 000 ignored", busy, 0);
    issue(3'b011);
    check("R3 cmd 011 ignored", busy, 0);
    load(16'h0070, 16'd0);
    d0 = done_seen; g0 = gnt_seen;
    issue(3'b001);
    repeat (3) @(negedge clk);
    check("R7 zero count done", done_seen - d0, 1);
    check("R7 zero count no access", gnt_seen - g0, 0);
    check("R7 zero count idle", busy, 0);
  endtask

  task automatic t_abort;
    logic [15:0] rd;
    int d0;
    word_mode = 1'b0;
    load(16'h0040, 16'd8);
    issue(3'b010);
    d0 = done_seen;
    host(1'b1, 16'h0001, rd);
    host(1'b1, 16'h0002, rd);
    reg_write(2'd0, 8'h99);
    check("R2 load ignored while busy", cur_addr, 16'h0042);
    issue(3'b100);
    check("R9 abort busy", busy, 0);
    check("R9 abort keeps addr", cur_addr, 16'h0042);
    host(1'b1, 16'h0055, rd);
    check("R9 no write after abort", mem[8'h42], 8'hEE);
    issue(3'b010);
    host(1'b1, 16'h0003, rd);
    check("R9 restart continues", cur_addr, 16'h0043);
    check("R9 count kept", busy, 1);
    issue(3'b111);
    repeat (3) @(negedge clk);
    check("R9 no done on abort", done_seen - d0, 0);
    check("R9 idle after abort", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'hEE;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_write();
    t_word_read();
    t_odd_word();
    t_stall();
    t_idle_and_cmds();
    t_abort();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule